// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous host port and an external asynchronous static RAM of 65,536 words by 16 bits. The host offers one request at a time over a valid/ready handshake: a read or a write, a 16-bit word address, 16 bits of write data and two lane selects, one per byte. The controller turns each accepted request into the RAM's strobe sequence. That sequence uses an active-low chip select, an active-low write strobe, an active-low output enable and active-low upper and lower byte enables. It also drives a split data path (output value, drive enable and input value) that a pad ring turns into the shared bidirectional bus.

Every phase length is a whole number of clock cycles. Each length is computed at elaboration time by rounding a picosecond timing minimum up to the clock period. A write is always ended by the write strobe rising. Chip select and the byte enables are held one cycle longer, and the write data stays driven during that cycle. A read keeps output enable low long enough for the slowest access path. The read word is captured on the last access edge and returned to the host with a one-cycle valid pulse. Unselected byte lanes come back as zero. After every read, idle cycles let the RAM release the bus before the controller can drive it again.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the controller is idle. In the cycle after a request is accepted, `req_ready` is low. A request held valid while the controller is busy is accepted on the first idle cycle.
- R2: A write first spends `WR_SETUP_CYC` cycles with `ram_cs_n` low and `ram_we_n` high. It then spends `WE_CYC` cycles with `ram_we_n` low. Throughout both phases `ram_oe_n` is high and the address and lane enables of the request are presented.
- R3: Every write ends with `ram_we_n` rising. During the next cycle `ram_cs_n` and the selected byte enables stay low. After that cycle all strobes are high.
- R4: `ram_dq_drive` is high exactly during the setup, pulse and end cycles of a write, and `ram_dq_out` then carries the request's write data. `ram_dq_drive` is never high while `ram_oe_n` is low.
- R5: `ram_addr` does not change during any run of cycles in which `ram_cs_n` stays low.
- R6: A read holds `ram_cs_n`, `ram_oe_n` and the selected byte enables low, with `ram_we_n` high and the bus not driven, for exactly `RD_CYC` cycles.
- R7: In the cycle after a read's access phase ends, `rsp_valid` is high for exactly one cycle. `rsp_rdata` then holds `ram_dq_in` as sampled on the clock edge that ends the access, with every unselected byte lane forced to zero.
- R8: After the access phase of every read, `TURN_CYC` cycles follow with all strobes high, the bus undriven and `req_ready` low.
- R9: Lane select bit 1 controls `ram_ub_n` and data bits 15:8. Lane select bit 0 controls `ram_lb_n` and bits 7:0. A partial write changes only its selected byte. A write with lane selects 00 leaves the memory unchanged.
- R10: While `rst_n` is low at a clock edge, all strobes go high, the bus is undriven, `rsp_valid` is low and `req_ready` is high.
- R11: Each phase length is the ceiling of its timing minimum divided by `CLK_PS`, and is at least 1.
  - `WE_CYC` is the larger of the rounded address-to-end and data-setup times.
  - `WR_SETUP_CYC` is the rounded write cycle time minus `WE_CYC` minus 1.
  - `RD_CYC` is the larger of the rounded access time and read cycle time.
  - `TURN_CYC` is the rounded bus release time.
  - With the defaults at a 4 ns clock these lengths are 1, 3, 4 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Byte lane selects, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| ram_addr | output | 16 | RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_ub_n | output | 1 | RAM upper byte enable, active low |
| ram_lb_n | output | 1 | RAM lower byte enable, active low |
| ram_dq_out | output | 16 | Value to drive onto the data bus |
| ram_dq_drive | output | 1 | Data bus output enable for the pad |
| ram_dq_in | input | 16 | Value read from the data bus |

## Verification
A sequencer counter or state that goes wrong shows at the strobe pins in the same cycle:
- a write pulse or access phase of the wrong length;
- a missing hold cycle, or drive left on;
- `req_ready` rising during the turnaround cycles.

The per-cycle comparison against the reference catches each of these in that cycle. A capture edge that comes too early returns the RAM model's not-yet-valid pattern in the response one cycle later. A wrong lane mapping corrupts the model memory, which shows at the next read of that word or at the final memory comparison.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the SRAM strobe controller.
// Assumes all timing values are given in picoseconds as positive integers.
package sram_ctl_pkg;

    // Sequencer phases; the pin decode and the FSM both key off these.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_TURN
    } seq_state_t;

    // Round a time up to whole clock periods.
    function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    // Larger of two integers.
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_req_latch.sv
`timescale 1ns/1ps
// Holds the address, write data and lane selects of the request being
// served. Loads on the accept edge only, so the RAM address and write data
// stay constant for the whole strobe sequence.
// Assumes accept is high for a single cycle per request.
module sram_req_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_lanes,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [1:0]        lanes_q,
    output logic [1:0]        lanes_nx
);

    // Lane selects as they will be after this edge, for registered pin decode.
    assign lanes_nx = accept ? req_lanes : lanes_q;

    // Capture the request fields when the handshake completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            lanes_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            lanes_q <= req_lanes;
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
// Phase sequencer. Walks write requests through setup, strobe and hold
// phases, and read requests through access and bus-turnaround phases. Each
// phase lasts a parameter number of cycles, counted down by one shared
// counter.
// Assumes every phase length parameter is at least 1.
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 3,
    parameter int ACCESS_CYC = 4,
    parameter int TURN_CYC   = 2,
    parameter int CNT_W      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    output logic       req_ready,
    output logic       accept,
    output logic       capture,
    output seq_state_t state_nx
);

    localparam logic [CNT_W-1:0] SETUP_LOAD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LOAD  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] ACCESS_LOAD = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD   = CNT_W'(TURN_CYC - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             cnt_done;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cnt_done  = (cnt_q == '0);

    // Next phase and counter reload; raises capture on the last access cycle.
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        state_nx = ST_WR_SETUP;
                        cnt_nx   = SETUP_LOAD;
                    end else begin
                        state_nx = ST_RD_ACCESS;
                        cnt_nx   = ACCESS_LOAD;
                    end
                end
            end
            ST_WR_SETUP: begin
                if (cnt_done) begin
                    state_nx = ST_WR_PULSE;
                    cnt_nx   = PULSE_LOAD;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            ST_WR_PULSE: begin
                if (cnt_done) begin
                    state_nx = ST_WR_HOLD;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            ST_WR_HOLD: begin
                state_nx = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (cnt_done) begin
                    state_nx = ST_RD_TURN;
                    cnt_nx   = TURN_LOAD;
                    capture  = 1'b1;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            ST_RD_TURN: begin
                if (cnt_done) begin
                    state_nx = ST_IDLE;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R1

endmodule

// File: rtl/sram_pin_drive.sv
`timescale 1ns/1ps
// Registers the RAM strobes and the bus drive enable from the phase being
// entered, so every pin toggles straight out of a flop.
// Assumes lanes_nx already reflects a request accepted on this edge.
module sram_pin_drive
    import sram_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state_nx,
    input  logic [1:0] lanes_nx,
    output logic       ram_cs_n,
    output logic       ram_we_n,
    output logic       ram_oe_n,
    output logic       ram_ub_n,
    output logic       ram_lb_n,
    output logic       ram_dq_drive
);

    logic cs_d, we_d, oe_d, ub_d, lb_d, drv_d;

    // Decode the pin levels that belong to the phase being entered.
    always_comb begin
        cs_d  = 1'b1;
        we_d  = 1'b1;
        oe_d  = 1'b1;
        ub_d  = 1'b1;
        lb_d  = 1'b1;
        drv_d = 1'b0;
        case (state_nx)
            ST_WR_SETUP, ST_WR_HOLD: begin
                cs_d  = 1'b0;
                ub_d  = !lanes_nx[1];
                lb_d  = !lanes_nx[0];
                drv_d = 1'b1;
            end
            ST_WR_PULSE: begin
                cs_d  = 1'b0;
                we_d  = 1'b0;
                ub_d  = !lanes_nx[1];
                lb_d  = !lanes_nx[0];
                drv_d = 1'b1;
            end
            ST_RD_ACCESS: begin
                cs_d = 1'b0;
                oe_d = 1'b0;
                ub_d = !lanes_nx[1];
                lb_d = !lanes_nx[0];
            end
            default: begin
                cs_d = 1'b1;
            end
        endcase
    end

    // Pin registers; reset parks every strobe inactive and releases the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_cs_n     <= 1'b1;
            ram_we_n     <= 1'b1;
            ram_oe_n     <= 1'b1;
            ram_ub_n     <= 1'b1;
            ram_lb_n     <= 1'b1;
            ram_dq_drive <= 1'b0;
        end else begin
            ram_cs_n     <= cs_d;
            ram_we_n     <= we_d;
            ram_oe_n     <= oe_d;
            ram_ub_n     <= ub_d;
            ram_lb_n     <= lb_d;
            ram_dq_drive <= drv_d;
        end
    end

    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> !ram_cs_n); // R2
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (!ram_cs_n && ram_dq_drive)); // R3
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> !ram_dq_drive); // R4

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
// Samples the RAM data bus on the edge that ends a read access, clears the
// unselected byte lanes and raises a one-cycle response valid.
// Assumes capture is high only on the final access cycle.
module sram_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [1:0]        lanes_q,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] masked;

    // One mask slice per byte lane.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] =
            lanes_q[g] ? ram_dq_in[g*LANE_W +: LANE_W] : '0;
    end

    // Response register: load on capture, pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= masked;
            end
        end
    end

    AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7

endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM strobe controller. Turns one host request at
// a time into chip-select, write, output-enable and byte-enable sequences
// whose phase lengths come from picosecond minimums rounded to CLK_PS.
// Assumes a single clock domain and an external pad that drives ram_dq_out
// onto the bus while ram_dq_drive is high.
module sram_strobe_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int CLK_PS       = 4000,
    parameter int T_ADDR_END_PS = 10000,
    parameter int T_DSETUP_PS  = 8000,
    parameter int T_WCYCLE_PS  = 15000,
    parameter int T_ACCESS_PS  = 15000,
    parameter int T_RCYCLE_PS  = 15000,
    parameter int T_RELEASE_PS = 7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_lanes,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic              ram_ub_n,
    output logic              ram_lb_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_drive,
    input  logic [DATA_W-1:0] ram_dq_in
);

    // R11: phase lengths from rounded timing minimums.
    localparam int WE_CYC = max_of(1, max_of(ps_to_cycles(T_ADDR_END_PS, CLK_PS),
                                             ps_to_cycles(T_DSETUP_PS, CLK_PS)));
    localparam int WR_SETUP_CYC = max_of(1, ps_to_cycles(T_WCYCLE_PS, CLK_PS) - WE_CYC - 1);
    localparam int RD_CYC = max_of(1, max_of(ps_to_cycles(T_ACCESS_PS, CLK_PS),
                                             ps_to_cycles(T_RCYCLE_PS, CLK_PS)));
    localparam int TURN_CYC = max_of(1, ps_to_cycles(T_RELEASE_PS, CLK_PS));
    localparam int MAX_CYC = max_of(max_of(WE_CYC, WR_SETUP_CYC), max_of(RD_CYC, TURN_CYC));
    localparam int CNT_W = max_of(1, $clog2(MAX_CYC + 1));

    seq_state_t state_nx;
    logic       accept;
    logic       capture;
    logic [1:0] lanes_q;
    logic [1:0] lanes_nx;

    sram_seq_fsm #(
        .SETUP_CYC (WR_SETUP_CYC),
        .PULSE_CYC (WE_CYC),
        .ACCESS_CYC(RD_CYC),
        .TURN_CYC  (TURN_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(req_ready),
        .accept   (accept),
        .capture  (capture),
        .state_nx (state_nx)
    );

    sram_req_latch #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_lanes(req_lanes),
        .addr_q   (ram_addr),
        .wdata_q  (ram_dq_out),
        .lanes_q  (lanes_q),
        .lanes_nx (lanes_nx)
    );

    sram_pin_drive u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_nx    (state_nx),
        .lanes_nx    (lanes_nx),
        .ram_cs_n    (ram_cs_n),
        .ram_we_n    (ram_we_n),
        .ram_oe_n    (ram_oe_n),
        .ram_ub_n    (ram_ub_n),
        .ram_lb_n    (ram_lb_n),
        .ram_dq_drive(ram_dq_drive)
    );

    sram_rd_capture #(
        .DATA_W(DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .lanes_q  (lanes_q),
        .ram_dq_in(ram_dq_in),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr)); // R5
    AST_TURN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_oe_n) |-> (!req_ready && ram_cs_n)); // R8
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(ram_oe_n)); // R7

endmodule

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;

    // Phase lengths worked out from the timing minimums at a 4 ns clock (R11).
    localparam int CLK_PS = 4000;
    localparam int C_WE    = ((10000 + CLK_PS - 1) / CLK_PS > (8000 + CLK_PS - 1) / CLK_PS)
                             ? (10000 + CLK_PS - 1) / CLK_PS : (8000 + CLK_PS - 1) / CLK_PS;
    localparam int C_WC    = (15000 + CLK_PS - 1) / CLK_PS;
    localparam int C_SETUP = (C_WC - C_WE - 1 < 1) ? 1 : C_WC - C_WE - 1;
    localparam int C_RD    = (15000 + CLK_PS - 1) / CLK_PS;
    localparam int C_TURN  = (7000 + CLK_PS - 1) / CLK_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] ram_addr;
    logic        ram_cs_n, ram_we_n, ram_oe_n, ram_ub_n, ram_lb_n;
    logic [15:0] ram_dq_out;
    logic        ram_dq_drive;
    logic [15:0] ram_dq_in = 16'hBAD0;

    int checks = 0;
    int bad = 0;
    bit taken = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sram_strobe_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_ub_n(ram_ub_n), .ram_lb_n(ram_lb_n),
        .ram_dq_out(ram_dq_out), .ram_dq_drive(ram_dq_drive), .ram_dq_in(ram_dq_in)
    );

    typedef struct {
        bit          cs_n, we_n, oe_n, ub_n, lb_n, drv, rdy, rv, act;
        logic [15:0] addr, wd, rd;
    } exp_t;

    exp_t        expq[$];
    logic [15:0] ref_mem [int];
    logic [15:0] ram_mem [int];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic exp_t idle_e();
        exp_t e;
        e.cs_n = 1; e.we_n = 1; e.oe_n = 1; e.ub_n = 1; e.lb_n = 1;
        e.drv = 0; e.rdy = 1; e.rv = 0; e.act = 0;
        e.addr = '0; e.wd = '0; e.rd = '0;
        return e;
    endfunction

    // Expected per-cycle pin sequence for one accepted request.
    function automatic void plan_op(input bit w, input logic [15:0] a, input logic [15:0] d,
                                    input logic [1:0] ln);
        exp_t e;
        logic [15:0] m;
        e = idle_e();
        e.rdy = 0; e.act = 1; e.addr = a; e.wd = d;
        e.ub_n = !ln[1]; e.lb_n = !ln[0]; e.cs_n = 0;
        if (w) begin
            e.drv = 1;
            for (int i = 0; i < C_SETUP; i++) expq.push_back(e);
            e.we_n = 0;
            for (int i = 0; i < C_WE; i++) expq.push_back(e);
            e.we_n = 1;
            expq.push_back(e);
            m = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
            if (ln[1]) m[15:8] = d[15:8];
            if (ln[0]) m[7:0] = d[7:0];
            ref_mem[int'(a)] = m;
        end else begin
            e.oe_n = 0;
            for (int i = 0; i < C_RD; i++) expq.push_back(e);
            m = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
            if (!ln[1]) m[15:8] = 8'h00;
            if (!ln[0]) m[7:0] = 8'h00;
            for (int i = 0; i < C_TURN; i++) begin
                exp_t t;
                t = idle_e();
                t.rdy = 0;
                t.rv = (i == 0);
                t.rd = m;
                expq.push_back(t);
            end
        end
    endfunction

    // Behavioural RAM: writes while select and strobe are low; read data
    // becomes valid only after C_RD cycles of stable access.
    int          rd_age = 0;
    logic [15:0] last_a = '0;
    always @(negedge clk) begin
        logic [15:0] m;
        if (!ram_cs_n && !ram_we_n) begin
            m = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 16'h0000;
            if (!ram_ub_n) m[15:8] = ram_dq_drive ? ram_dq_out[15:8] : 8'hEE;
            if (!ram_lb_n) m[7:0]  = ram_dq_drive ? ram_dq_out[7:0]  : 8'hEE;
            ram_mem[int'(ram_addr)] = m;
        end
        if (!ram_cs_n && !ram_oe_n && ram_we_n) begin
            if (rd_age == 0 || ram_addr != last_a) rd_age = 1;
            else rd_age = rd_age + 1;
            last_a = ram_addr;
        end else begin
            rd_age = 0;
        end
        if (rd_age >= C_RD) begin
            m = ram_mem.exists(int'(last_a)) ? ram_mem[int'(last_a)] : 16'h0000;
            if (ram_ub_n) m[15:8] = 8'hA5;
            if (ram_lb_n) m[7:0]  = 8'h5A;
            ram_dq_in = m;
        end else begin
            ram_dq_in = 16'hBAD0;
        end
    end

    // Cycle-by-cycle comparison against the expected sequence.
    always @(negedge clk) begin : refm
        exp_t e;
        if (rst_n && !done) begin
            e = (expq.size() > 0) ? expq.pop_front() : idle_e();
            chk(req_ready == e.rdy, "R1 R8 req_ready", 32'(req_ready), 32'(e.rdy));
            chk({ram_cs_n, ram_we_n, ram_oe_n} == {e.cs_n, e.we_n, e.oe_n},
                "R2 R3 R6 R11 strobes cs/we/oe",
                32'({ram_cs_n, ram_we_n, ram_oe_n}), 32'({e.cs_n, e.we_n, e.oe_n}));
            chk({ram_ub_n, ram_lb_n} == {e.ub_n, e.lb_n}, "R9 byte enables",
                32'({ram_ub_n, ram_lb_n}), 32'({e.ub_n, e.lb_n}));
            chk(ram_dq_drive == e.drv, "R4 bus drive", 32'(ram_dq_drive), 32'(e.drv));
            if (e.drv) chk(ram_dq_out == e.wd, "R4 write data", 32'(ram_dq_out), 32'(e.wd));
            if (e.act) chk(ram_addr == e.addr, "R5 address", 32'(ram_addr), 32'(e.addr));
            chk(rsp_valid == e.rv, "R7 rsp_valid", 32'(rsp_valid), 32'(e.rv));
            if (e.rv) chk(rsp_rdata == e.rd, "R7 R9 read data", 32'(rsp_rdata), 32'(e.rd));
            if (req_valid && e.rdy) begin
                plan_op(req_write, req_addr, req_wdata, req_lanes);
                taken = 1;
            end
        end
    end

    task automatic issue(input bit w, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] ln);
        taken = 0;
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_lanes = ln;
        do @(posedge clk); while (!taken);
        #1;
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_lanes = '0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R10: reset state at the ports
        chk({ram_cs_n, ram_we_n, ram_oe_n, ram_ub_n, ram_lb_n} == 5'b11111, "R10 strobes in reset",
            32'({ram_cs_n, ram_we_n, ram_oe_n, ram_ub_n, ram_lb_n}), 32'h1f);
        chk(!ram_dq_drive && !rsp_valid, "R10 drive and rsp_valid in reset",
            32'({ram_dq_drive, rsp_valid}), 32'h0);
        chk(req_ready, "R10 ready in reset", 32'(req_ready), 32'h1);
        @(posedge clk); #1;
        rst_n = 1;
        gap(2);
        // full-word write and readback (R2 R3 R6 R7)
        issue(1, 16'h0010, 16'hCAFE, 2'b11);
        gap(1);
        issue(0, 16'h0010, 16'h0000, 2'b11);
        // partial writes, each lane alone (R9)
        issue(1, 16'h0010, 16'h1234, 2'b10);
        issue(1, 16'h0010, 16'h5678, 2'b01);
        issue(0, 16'h0010, 16'h0000, 2'b11);
        // no-lane write leaves memory unchanged (R9)
        issue(1, 16'h0010, 16'hFFFF, 2'b00);
        issue(0, 16'h0010, 16'h0000, 2'b11);
        // single-lane reads return zero elsewhere (R7)
        issue(0, 16'h0010, 16'h0000, 2'b10);
        issue(0, 16'h0010, 16'h0000, 2'b01);
        issue(0, 16'h0010, 16'h0000, 2'b00);
        // top and bottom of the address space (R5)
        issue(1, 16'hFFFF, 16'hA55A, 2'b11);
        issue(1, 16'h0000, 16'h0F0F, 2'b11);
        issue(0, 16'hFFFF, 16'h0000, 2'b11);
        issue(0, 16'h0000, 16'h0000, 2'b11);
        gap(3);
        // mixed traffic held valid back to back (R1 R8)
        for (int k = 0; k < 300; k++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            issue(1'($urandom_range(0, 1)), {r, 8'h00, r, r}, 16'($urandom),
                  2'($urandom_range(0, 3)));
            if ($urandom_range(0, 3) == 0) gap(int'($urandom_range(1, 3)));
        end
        gap(12);
        // memory contents match the lane-accurate reference (R9)
        foreach (ref_mem[a]) begin
            logic [15:0] got;
            got = ram_mem.exists(a) ? ram_mem[a] : 16'h0000;
            chk(got == ref_mem[a], "R9 stored word", 32'(got), 32'(ref_mem[a]));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule